// File: doc/BRIEF.md
# Inbound Sample Packet Framer

The framer gathers the 32-bit samples of one receive channel and turns them into constant-size 512-byte packets on a 32-bit word stream headed for the host. Each packet opens with two header words. The first carries the status flags, the front-end signal strength, the channel, a tag and the payload length in bytes. The second carries the time-base value at which the first sample of the packet was captured. The payload follows, and zero words fill the rest of the packet.

A packet is closed when its payload region holds 126 samples (504 bytes), or earlier on a flush request. Storage is double-buffered, so one payload buffer fills while the other drains. Samples are dropped only when both buffers are occupied. Such a drop raises an overrun flag, which the next header carries. Transmit-side underrun and late-discard events arrive as pulses and are likewise kept until a header has carried them.

Top module: `inpkt_framer`

## Requirements
- R1: After reset `pkt_valid_o` is low and stays low until a packet has been closed, and no status flag is pending.
- R2: Every packet is exactly 128 words. `pkt_sop_o` marks word 0 and `pkt_eop_o` marks word 127. While `pkt_valid_o` is high and `pkt_ready_i` is low, the valid signal and the data word hold.
- R3: Header word 0 layout: bit 31 overrun, bit 30 underrun, bit 29 dropped, bits 28:27 zero, bits 26:21 signal strength, bits 20:16 channel, bits 15:13 zero, bits 12:9 tag, bits 8:0 payload length in bytes.
- R4: When the 126th sample is accepted the packet closes without a flush, with a length field of 504. The payload words appear in arrival order.
- R5: Header word 1 equals the `time_i` value present on the clock edge that accepted the first sample of the packet.
- R6: A flush closes a partial packet with length 4 times the sample count. All words after the payload are zero.
- R7: A flush while no sample is held has no effect: no packet is emitted and the next packet is unaffected.
- R8: A sample that arrives while one buffer is full and the other is still unsent is discarded. The overrun flag is then set in the header of the next packet whose header is formed after the discard.
- R9: Underrun and dropped pulses set sticky flags. A flag is cleared once a header has carried it, so the following packet shows it clear unless a new event occurred.
- R10: Samples presented while `chan_i` is 0x1F are ignored. They are neither stored nor counted as overrun.
- R11: Samples that arrive while the previous packet is being sent, with `pkt_ready_i` high, are captured without loss into the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | 32 | Sample word |
| time_i | input | 32 | Free-running sample time base |
| chan_i | input | 5 | Logical channel number placed in headers |
| tag_i | input | 4 | Tag placed in headers |
| rssi_i | input | 6 | Front-end signal strength |
| flush_i | input | 1 | Close the current partial packet |
| tx_underrun_i | input | 1 | Pulse: transmit side starved mid-burst |
| tx_late_drop_i | input | 1 | Pulse: outbound packet discarded as late |
| pkt_ready_i | input | 1 | Host side accepts a word |
| pkt_valid_o | output | 1 | Output word valid |
| pkt_data_o | output | 32 | Output word |
| pkt_sop_o | output | 1 | First word of a packet |
| pkt_eop_o | output | 1 | Last word of a packet |

## Verification
The bench builds the framer with its default 512-byte packet size, giving 126 payload words and two 126-entry buffers. With these values the automatic close at exactly 504 bytes is reachable, as are flush lengths from 1 up to 125 samples and the state in which both buffers are full under backpressure. A table walk covers several flush lengths, one of them under an alternating ready. Directed runs then cover the overrun drop, the flag clearing, the reserved channel, the empty flush, and continuous capture across a packet boundary.

// File: rtl/inpkt_pkg.sv
package inpkt_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HDR_WORDS = 2;
  localparam logic [4:0]  CTRL_CHAN = 5'h1f;

  // flag vector order: {overrun, underrun, dropped}
  localparam int unsigned N_FLAGS = 3;
  localparam int unsigned F_OVR   = 2;
  localparam int unsigned F_UND   = 1;
  localparam int unsigned F_DRP   = 0;

  typedef struct packed {
    logic [N_FLAGS-1:0] flags;
    logic               sob;
    logic               eob;
    logic [5:0]         rssi;
    logic [4:0]         chan;
    logic [2:0]         zero;
    logic [3:0]         tag;
    logic [8:0]         len_b;
  } hdr_t;

  function automatic logic [WORD_W-1:0] build_hdr(
    input logic [N_FLAGS-1:0] flags,
    input logic [5:0]         rssi,
    input logic [4:0]         chan,
    input logic [3:0]         tag,
    input logic [8:0]         len_b
  );
    hdr_t h;
    h.flags = flags;
    h.sob   = 1'b0;
    h.eob   = 1'b0;
    h.rssi  = rssi;
    h.chan  = chan;
    h.zero  = '0;
    h.tag   = tag;
    h.len_b = len_b;
    return h;
  endfunction
endpackage

// File: rtl/inpkt_status.sv
module inpkt_status
  import inpkt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] clr_i,
  output logic [N_FLAGS-1:0] flags_o
);
  logic [N_FLAGS-1:0] flag_q;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    // a new event in the clearing cycle survives for the next header
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
    end

    p_set_sticks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/inpkt_bankbuf.sv
module inpkt_bankbuf
  import inpkt_pkg::*;
#(
  parameter int unsigned PAY_WORDS = 126,
  localparam int unsigned CW = $clog2(PAY_WORDS + 1),
  localparam int unsigned IW = $clog2(PAY_WORDS),
  localparam int unsigned AW = $clog2(2 * PAY_WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   s_valid_i,
  input  logic [WORD_W-1:0]      s_data_i,
  input  logic                   chan_ok_i,
  input  logic [31:0]            time_i,
  input  logic                   flush_i,
  input  logic                   rd_bank_i,
  input  logic [IW-1:0]          rd_idx_i,
  input  logic                   release_i,
  output logic [WORD_W-1:0]      rd_data_o,
  output logic [1:0]             rdy_o,
  output logic [1:0][CW-1:0]     len_o,
  output logic [1:0][31:0]       ts_o,
  output logic                   drop_o
);
  logic [WORD_W-1:0] mem_q [2*PAY_WORDS];
  logic              wr_bank_q;
  logic [CW-1:0]     cnt_q;
  logic              flush_pend_q;
  logic [1:0]        rdy_q;
  logic [1:0][CW-1:0] len_q;
  logic [1:0][31:0]  ts_q;

  logic          full, flush_req, seal, accept, tgt_bank;
  logic [IW-1:0] tgt_idx;
  logic [AW-1:0] waddr, raddr;
  logic [1:0]    rdy_d;

  assign full      = (cnt_q == CW'(PAY_WORDS));
  assign flush_req = flush_pend_q | flush_i;
  // close only into a free spare bank
  assign seal      = (full | (flush_req & (cnt_q != '0))) & ~rdy_q[~wr_bank_q];
  assign accept    = s_valid_i & chan_ok_i & (seal | ~full);
  assign drop_o    = s_valid_i & chan_ok_i & ~accept;
  assign tgt_bank  = seal ? ~wr_bank_q : wr_bank_q;
  assign tgt_idx   = seal ? '0 : cnt_q[IW-1:0];
  assign waddr     = (tgt_bank ? AW'(PAY_WORDS) : '0) + AW'(tgt_idx);
  assign raddr     = (rd_bank_i ? AW'(PAY_WORDS) : '0) + AW'(rd_idx_i);
  assign rd_data_o = mem_q[raddr];

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[waddr] <= s_data_i;
  end

  always_comb begin
    rdy_d = rdy_q;
    if (release_i) rdy_d[rd_bank_i] = 1'b0;
    if (seal)      rdy_d[wr_bank_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q    <= 1'b0;
      cnt_q        <= '0;
      flush_pend_q <= 1'b0;
      rdy_q        <= '0;
      len_q        <= '0;
      ts_q         <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (seal) begin
        len_q[wr_bank_q] <= cnt_q;
        wr_bank_q        <= ~wr_bank_q;
        cnt_q            <= CW'(accept);
      end else begin
        cnt_q <= cnt_q + CW'(accept);
      end
      if (accept && tgt_idx == '0) ts_q[tgt_bank] <= time_i;
      flush_pend_q <= (seal || cnt_q == '0) ? 1'b0 : flush_req;
    end
  end

  assign rdy_o = rdy_q;
  assign len_o = len_q;
  assign ts_o  = ts_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PAY_WORDS));
  p_nonempty_b0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q[0]) |-> len_q[0] != '0);
  p_nonempty_b1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q[1]) |-> len_q[1] != '0);
endmodule

// File: rtl/inpkt_emit.sv
module inpkt_emit
  import inpkt_pkg::*;
#(
  parameter int unsigned PKT_WORDS = 128,
  localparam int unsigned PAY_WORDS = PKT_WORDS - HDR_WORDS,
  localparam int unsigned CW = $clog2(PAY_WORDS + 1),
  localparam int unsigned IW = $clog2(PAY_WORDS),
  localparam int unsigned WW = $clog2(PKT_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         rdy_i,
  input  logic [1:0][CW-1:0] len_i,
  input  logic [1:0][31:0]   ts_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic [5:0]         rssi_i,
  input  logic [4:0]         chan_i,
  input  logic [3:0]         tag_i,
  input  logic               out_ready_i,
  output logic               rd_bank_o,
  output logic [IW-1:0]      rd_idx_o,
  output logic               release_o,
  output logic [N_FLAGS-1:0] flags_clr_o,
  output logic               out_valid_o,
  output logic [WORD_W-1:0]  out_data_o,
  output logic               out_sop_o,
  output logic               out_eop_o
);
  logic              rd_bank_q, lat_q;
  logic [WW-1:0]     widx_q;
  logic [WORD_W-1:0] hdr_q;
  logic              pending, latch, fire, last, in_pay;
  logic [CW-1:0]     len_cur;

  assign len_cur     = len_i[rd_bank_q];
  assign pending     = rdy_i[rd_bank_q];
  // header frozen once per packet so stalled data stays stable
  assign latch       = pending & ~lat_q;
  assign flags_clr_o = latch ? flags_i : '0;
  assign out_valid_o = pending & lat_q;
  assign fire        = out_valid_o & out_ready_i;
  assign last        = (widx_q == WW'(PKT_WORDS - 1));
  assign release_o   = fire & last;
  assign in_pay      = (int'(widx_q) >= HDR_WORDS) &&
                       (int'(widx_q) < int'(len_cur) + HDR_WORDS);
  assign rd_idx_o    = IW'(widx_q - WW'(HDR_WORDS));
  assign rd_bank_o   = rd_bank_q;
  assign out_sop_o   = (widx_q == '0);
  assign out_eop_o   = last;

  always_comb begin
    if (widx_q == '0)      out_data_o = hdr_q;
    else if (widx_q == 1)  out_data_o = ts_i[rd_bank_q];
    else if (in_pay)       out_data_o = rd_data_i;
    else                   out_data_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bank_q <= 1'b0;
      lat_q     <= 1'b0;
      widx_q    <= '0;
      hdr_q     <= '0;
    end else begin
      if (latch) begin
        lat_q <= 1'b1;
        hdr_q <= build_hdr(flags_i, rssi_i, chan_i, tag_i, 9'(len_cur) << 2);
      end
      if (fire) begin
        widx_q <= last ? '0 : widx_q + 1'b1;
        if (last) begin
          lat_q     <= 1'b0;
          rd_bank_q <= ~rd_bank_q;
        end
      end
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  p_mbz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> (out_data_o[28:27] == '0 && out_data_o[15:13] == '0));
  p_len_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |->
      (out_data_o[8:0] <= 9'(PAY_WORDS * 4) && out_data_o[1:0] == '0));
endmodule

// File: rtl/inpkt_framer.sv
module inpkt_framer
  import inpkt_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 512,
  localparam int unsigned PKT_WORDS = PKT_BYTES / 4,
  localparam int unsigned PAY_WORDS = PKT_WORDS - HDR_WORDS,
  localparam int unsigned CW = $clog2(PAY_WORDS + 1),
  localparam int unsigned IW = $clog2(PAY_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        smp_valid_i,
  input  logic [31:0] smp_data_i,
  input  logic [31:0] time_i,
  input  logic [4:0]  chan_i,
  input  logic [3:0]  tag_i,
  input  logic [5:0]  rssi_i,
  input  logic        flush_i,
  input  logic        tx_underrun_i,
  input  logic        tx_late_drop_i,
  input  logic        pkt_ready_i,
  output logic        pkt_valid_o,
  output logic [31:0] pkt_data_o,
  output logic        pkt_sop_o,
  output logic        pkt_eop_o
);
  logic               chan_ok, drop, rd_bank, release_w;
  logic [IW-1:0]      rd_idx;
  logic [WORD_W-1:0]  rd_data;
  logic [1:0]         rdy;
  logic [1:0][CW-1:0] len;
  logic [1:0][31:0]   ts;
  logic [N_FLAGS-1:0] flags, flags_set, flags_clr;

  assign chan_ok   = (chan_i != CTRL_CHAN);
  assign flags_set = {drop, tx_underrun_i, tx_late_drop_i};

  inpkt_bankbuf #(.PAY_WORDS(PAY_WORDS)) u_buf (
    .clk_i, .rst_ni,
    .s_valid_i (smp_valid_i),
    .s_data_i  (smp_data_i),
    .chan_ok_i (chan_ok),
    .time_i,
    .flush_i,
    .rd_bank_i (rd_bank),
    .rd_idx_i  (rd_idx),
    .release_i (release_w),
    .rd_data_o (rd_data),
    .rdy_o     (rdy),
    .len_o     (len),
    .ts_o      (ts),
    .drop_o    (drop)
  );

  inpkt_status u_status (
    .clk_i, .rst_ni,
    .set_i   (flags_set),
    .clr_i   (flags_clr),
    .flags_o (flags)
  );

  inpkt_emit #(.PKT_WORDS(PKT_WORDS)) u_emit (
    .clk_i, .rst_ni,
    .rdy_i       (rdy),
    .len_i       (len),
    .ts_i        (ts),
    .rd_data_i   (rd_data),
    .flags_i     (flags),
    .rssi_i,
    .chan_i,
    .tag_i,
    .out_ready_i (pkt_ready_i),
    .rd_bank_o   (rd_bank),
    .rd_idx_o    (rd_idx),
    .release_o   (release_w),
    .flags_clr_o (flags_clr),
    .out_valid_o (pkt_valid_o),
    .out_data_o  (pkt_data_o),
    .out_sop_o   (pkt_sop_o),
    .out_eop_o   (pkt_eop_o)
  );

  p_ctrl_chan_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && chan_i == CTRL_CHAN) |-> !drop);
  p_drop_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> flags[F_OVR]);
endmodule

// File: tb/inpkt_framer_tb_top.sv
`timescale 1ns/1ps
module inpkt_framer_tb_top;
  localparam int PW = 128;
  localparam int PAYW = 126;
  // {samples before flush, expected length in bytes}
  localparam int FL_VEC [0:4][0:1] = '{'{1, 4}, '{2, 8}, '{37, 148}, '{125, 500}, '{126, 504}};

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, flush = 0, und = 0, late = 0, ready = 0;
  logic [31:0] smp_data = 0, tcnt = 0;
  logic [4:0] chan = 5'd3;
  logic [3:0] tag = 4'h9;
  logic [5:0] rssi = 6'h2a;
  logic pkt_valid, pkt_sop, pkt_eop;
  logic [31:0] pkt_data;
  logic [31:0] pkt [PW];
  int n_run = 0, n_fail = 0, frame_err = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 32'd1;

  inpkt_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .time_i(tcnt), .chan_i(chan), .tag_i(tag), .rssi_i(rssi), .flush_i(flush),
    .tx_underrun_i(und), .tx_late_drop_i(late), .pkt_ready_i(ready),
    .pkt_valid_o(pkt_valid), .pkt_data_o(pkt_data), .pkt_sop_o(pkt_sop), .pkt_eop_o(pkt_eop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(input int n, input logic [31:0] base, output logic [31:0] ts0);
    ts0 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) ts0 = tcnt;
      smp_valid = 1; smp_data = base + 32'(i);
    end
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic collect(input bit stall);
    int n = 0, cyc = 0;
    frame_err = 0;
    while (n < PW) begin
      @(negedge clk);
      ready = stall ? cyc[0] : 1'b1;
      cyc++;
      if (pkt_valid && ready) begin
        if (pkt_sop !== (n == 0) || pkt_eop !== (n == PW - 1)) frame_err++;
        pkt[n] = pkt_data;
        n++;
      end
    end
    @(negedge clk); ready = 0;
  endtask

  task automatic check_pkt(input string req, input int words, input logic [31:0] base,
                           input logic [31:0] ts, input logic [2:0] flg);
    int bad = 0;
    chk({req, " R2 framing"}, 32'(frame_err), 0);
    chk({req, " R3 header"}, pkt[0],
        {flg, 2'b00, rssi, chan, 3'b000, tag, 9'(words * 4)});
    chk({req, " R5 timestamp"}, pkt[1], ts);
    for (int i = 0; i < PAYW; i++) begin
      if (i < words) begin if (pkt[i + 2] !== base + 32'(i)) bad++; end
      else if (pkt[i + 2] !== 32'd0) bad++;
    end
    chk({req, " R4/R6 payload+pad"}, 32'(bad), 0);
  endtask

  task automatic idle_check(input string req, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pkt_valid) seen++;
    end
    chk(req, 32'(seen), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ts_a, ts_b, ts_c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    idle_check("R1 idle after reset", 10);

    // table walk: flush lengths, R6 / R4
    for (int v = 0; v < 5; v++) begin
      push(FL_VEC[v][0], 32'h100 * 32'(v + 1), ts_a);
      pulse_flush();
      collect(v == 2);
      check_pkt("R6 table", FL_VEC[v][1] / 4, 32'h100 * 32'(v + 1), ts_a, 3'b000);
    end

    // R7 flush with nothing held
    pulse_flush();
    idle_check("R7 empty flush", 30);
    push(2, 32'h7000, ts_a);
    pulse_flush();
    collect(0);
    check_pkt("R7 next packet", 2, 32'h7000, ts_a, 3'b000);

    // R10 reserved channel
    chan = 5'h1f;
    push(5, 32'hdead0000, ts_a);
    chan = 5'd17; tag = 4'h4; rssi = 6'h15;
    pulse_flush();
    idle_check("R10 ctrl channel not stored", 30);
    push(3, 32'h8000, ts_a);
    pulse_flush();
    collect(0);
    check_pkt("R10 following packet", 3, 32'h8000, ts_a, 3'b000);

    // R9 underrun / dropped sticky
    @(negedge clk); und = 1; late = 1;
    @(negedge clk); und = 0; late = 0;
    push(2, 32'h9000, ts_a);
    pulse_flush();
    collect(0);
    check_pkt("R9 flags carried", 2, 32'h9000, ts_a, 3'b011);
    push(1, 32'h9100, ts_a);
    pulse_flush();
    collect(0);
    check_pkt("R9 flags cleared", 1, 32'h9100, ts_a, 3'b000);

    // R8 overrun with both buffers occupied
    ready = 0;
    push(126, 32'h10000, ts_a);
    push(126, 32'h20000, ts_b);
    push(3, 32'h30000, ts_c);
    collect(0);
    check_pkt("R8 first bank", 126, 32'h10000, ts_a, 3'b000);
    collect(0);
    check_pkt("R8 overrun flagged", 126, 32'h20000, ts_b, 3'b100);
    push(1, 32'h31000, ts_a);
    pulse_flush();
    collect(0);
    check_pkt("R8 overrun cleared", 1, 32'h31000, ts_a, 3'b000);

    // R11 continuous capture across a boundary
    fork
      begin
        push(136, 32'h40000, ts_a);
        pulse_flush();
      end
      begin
        collect(0);
        check_pkt("R11 packet A", 126, 32'h40000, ts_a, 3'b000);
        collect(0);
        check_pkt("R11 packet B", 10, 32'h40000 + 32'd126, ts_a + 32'd126, 3'b000);
      end
    join
    idle_check("R11 nothing extra", 20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule